// File: doc/BRIEF.md
# Dual Bidirectional Port with Bit-7 Edge Interrupt

This block provides two 8-bit general-purpose ports, A and B. Each port has an output register and a direction register. A direction bit of 1 makes that pin an output driven from the output register. A direction bit of 0 makes it an input taken from the pad. A port data read returns the merged pin value: output bits where the direction is 1 and synchronized pad bits where it is 0.

Bit 7 of the merged port A value feeds an edge detector. Its polarity and its interrupt enable are set by the address of an edge-control write, not by the data. The detector sees the merged value, so a CPU write to the port A output or direction register can raise the edge flag without any pad activity.

The block also holds the shared interrupt flag register. Bit 7 is a timer flag, set and cleared by an external timer through two strobes and gated by an external enable. Bit 6 is the edge flag. The single interrupt line is high whenever an enabled flag is set.

Top module: `dual_port_edge_irq`

## Requirements
- R1: After reset the output and direction registers of both ports are 0, the edge enable is 0, the edge polarity is falling, both flags are 0 and `irq` is 0.
- R2: The bus address selects the target as follows. With address bit 2 at 0 the access targets a port: bit 1 picks port B (1) or port A (0), bit 0 picks the direction register (1) or the data register (0), and bit 4 is ignored. `bus_rdata` is combinational on `bus_addr`.
- R3: A port data read returns (out AND dir) OR (in AND NOT dir), where `in` is the synchronized pad value. A direction register read returns the direction register.
- R4: `pa_out`/`pb_out` equal the output registers, and `pa_oe`/`pb_oe` equal the direction registers. An output enable bit of 1 means that pin drives.
- R5: Pad inputs pass through two flip-flop stages. A pad change made between clock edges shows in a port read after the second rising edge and not after the first.
- R6: A write with address bit 4 at 0 and bit 2 at 1 is an edge-control write. Address bit 1 sets the edge interrupt enable, and address bit 0 sets the polarity (0 falling, 1 rising). A write with bits 4 and 2 both at 1 changes no port or edge state.
- R7: Bit 6 of the flag register sets when bit 7 of the merged port A value moves in the selected direction. A move in the opposite direction leaves it clear.
- R8: A write to the port A output or direction register that moves merged bit 7 in the selected direction sets the edge flag.
- R9: A read with address bit 2 and bit 0 both at 1 returns {timer flag, edge flag, 6'b0}. It clears the edge flag on that clock edge and leaves the timer flag unchanged. A new edge on the same edge wins over the clear.
- R10: `tmr_set` sets the timer flag and `tmr_clr` clears it. If both are high in the same cycle, the set wins.
- R11: `irq` is high exactly when (timer flag AND `tmr_irq_en`) OR (edge flag AND edge enable) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; triggers read side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on address |
| pa_in | input | 8 | Port A pad inputs (asynchronous) |
| pa_out | output | 8 | Port A pad output values |
| pa_oe | output | 8 | Port A per-bit output enables |
| pb_in | input | 8 | Port B pad inputs (asynchronous) |
| pb_out | output | 8 | Port B pad output values |
| pb_oe | output | 8 | Port B per-bit output enables |
| tmr_set | input | 1 | Timer flag set strobe |
| tmr_clr | input | 1 | Timer flag clear strobe |
| tmr_irq_en | input | 1 | Timer interrupt enable |
| irq | output | 1 | Combined interrupt output |

## Verification
The bench targets an edge raised only by a direction-register write while the pad stays still. A design that watched the raw pad instead of the merged value would miss this edge and never set the flag. It checks that an edge against the programmed polarity stays silent, which catches an inverted or ignored polarity bit. It reads the flag register with the timer flag set, to catch a read that clears both flags. It times pad changes edge by edge, to catch a missing or extra synchronizer stage. It also writes with address bits 4 and 2 both set, and with bit 4 set on a port address, to catch decode that ignores or misuses bit 4.

// File: rtl/dual_port_edge_irq.sv
module dual_port_edge_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic       tmr_set,
  input  logic       tmr_clr,
  input  logic       tmr_irq_en,
  output logic       irq
);

  logic [7:0] a_sync [SYNC_STAGES];
  logic [7:0] b_sync [SYNC_STAGES];
  logic [7:0] a_out, a_dir, b_out, b_dir;
  logic       edge_en, edge_rise, bit7_prev;
  logic       edge_flag, tmr_flag;

  wire port_sel  = ~bus_addr[2];
  wire ctrl_wr   = bus_wr & bus_addr[2] & ~bus_addr[4];
  wire flag_rd   = bus_rd & bus_addr[2] & bus_addr[0];
  wire a_out_wr  = bus_wr & port_sel & ~bus_addr[1] & ~bus_addr[0];
  wire a_dir_wr  = bus_wr & port_sel & ~bus_addr[1] &  bus_addr[0];
  wire b_out_wr  = bus_wr & port_sel &  bus_addr[1] & ~bus_addr[0];
  wire b_dir_wr  = bus_wr & port_sel &  bus_addr[1] &  bus_addr[0];

  wire [7:0] a_in  = a_sync[SYNC_STAGES-1];
  wire [7:0] b_in  = b_sync[SYNC_STAGES-1];
  wire [7:0] a_pin = (a_out & a_dir) | (a_in & ~a_dir);
  wire [7:0] b_pin = (b_out & b_dir) | (b_in & ~b_dir);

  wire edge_hit = (bit7_prev != a_pin[7]) && (a_pin[7] == edge_rise);

  always_ff @(posedge clk) begin
    a_sync[0] <= pa_in;
    b_sync[0] <= pb_in;
    for (int i = 1; i < SYNC_STAGES; i++) begin
      a_sync[i] <= a_sync[i-1];
      b_sync[i] <= b_sync[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_out <= '0;
      a_dir <= '0;
      b_out <= '0;
      b_dir <= '0;
    end else begin
      if (a_out_wr) a_out <= bus_wdata;
      if (a_dir_wr) a_dir <= bus_wdata;
      if (b_out_wr) b_out <= bus_wdata;
      if (b_dir_wr) b_dir <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_en   <= 1'b0;
      edge_rise <= 1'b0;
      bit7_prev <= 1'b0;
      edge_flag <= 1'b0;
      tmr_flag  <= 1'b0;
    end else begin
      bit7_prev <= a_pin[7];
      if (ctrl_wr) begin
        edge_en   <= bus_addr[1];
        edge_rise <= bus_addr[0];
      end
      if (edge_hit)     edge_flag <= 1'b1;
      else if (flag_rd) edge_flag <= 1'b0;
      if (tmr_set)      tmr_flag  <= 1'b1;
      else if (tmr_clr) tmr_flag  <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (port_sel) begin
      case (bus_addr[1:0])
        2'b00:   bus_rdata = a_pin;
        2'b01:   bus_rdata = a_dir;
        2'b10:   bus_rdata = b_pin;
        default: bus_rdata = b_dir;
      endcase
    end else if (bus_addr[0]) begin
      bus_rdata = {tmr_flag, edge_flag, 6'b0};
    end
  end

  assign pa_out = a_out;
  assign pa_oe  = a_dir;
  assign pb_out = b_out;
  assign pb_oe  = b_dir;
  assign irq    = (tmr_flag & tmr_irq_en) | (edge_flag & edge_en);

endmodule

// File: rtl/dual_port_edge_irq_chk.sv
module dual_port_edge_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic [7:0] pa_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_out,
  input logic [7:0] pb_oe,
  input logic       tmr_set,
  input logic       tmr_clr,
  input logic       tmr_irq_en,
  input logic       irq,
  input logic       edge_hit,
  input logic       edge_en,
  input logic       edge_flag,
  input logic       tmr_flag
);

  // R4
  a_dir_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[2:0] == 3'b001) |=> pa_oe == $past(bus_wdata));

  // R6
  tmr_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[4] && bus_addr[2]) |=>
      ($stable(pa_out) && $stable(pa_oe) && $stable(pb_out) && $stable(pb_oe) && $stable(edge_en)));

  // R9
  flag_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[2] && bus_addr[0] && !edge_hit) |=> !edge_flag);

  // R9
  flag_rd_keep_tmr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[2] && bus_addr[0] && !tmr_set && !tmr_clr) |=> $stable(tmr_flag));

  // R10
  tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_set |=> tmr_flag);

  // R7
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> edge_flag);

  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_irq_en && !edge_en) |-> !irq);

endmodule

bind dual_port_edge_irq dual_port_edge_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
  .tmr_set(tmr_set), .tmr_clr(tmr_clr), .tmr_irq_en(tmr_irq_en), .irq(irq),
  .edge_hit(edge_hit), .edge_en(edge_en), .edge_flag(edge_flag), .tmr_flag(tmr_flag)
);

// File: tb/dual_port_edge_irq_tb.sv
module dual_port_edge_irq_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pa_in = '0, pb_in = '0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe;
  logic       tmr_set = 0, tmr_clr = 0, tmr_irq_en = 0;
  logic       irq;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  dual_port_edge_irq u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0; bus_addr = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0; bus_addr = '0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 pa_oe", pa_oe, 0);
    chk("R1 pb_out", pb_out, 0);
    chk("R1 irq", irq, 0);
    rd(5'h05, v); chk("R1 flags", v, 0);
  endtask

  task automatic t_port_b;
    logic [7:0] v;
    wr(5'h03, 8'hF0); wr(5'h02, 8'hA5); pb_in = 8'h3C; cyc(3);
    rd(5'h02, v); chk("R3 merged B", v, 8'hAC);
    rd(5'h03, v); chk("R3 dir B", v, 8'hF0);
    chk("R4 pb_out", pb_out, 8'hA5);
    chk("R4 pb_oe", pb_oe, 8'hF0);
    wr(5'h12, 8'h5A); chk("R2 A4 alias", pb_out, 8'h5A);
    chk("R2 port A untouched", pa_out, 0);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    @(negedge clk); bus_addr = 5'h00; pa_in = 8'h81;
    @(posedge clk); #1 chk("R5 one stage", bus_rdata, 8'h00);
    @(posedge clk); #1 chk("R5 two stages", bus_rdata, 8'h81);
    cyc(2);
    rd(5'h05, v); chk("R7 rise ignored when falling", v, 0);
  endtask

  task automatic t_fall;
    logic [7:0] v;
    wr(5'h06, 0);
    pa_in = 8'h01; cyc(4);
    chk("R11 irq edge", irq, 1);
    rd(5'h05, v); chk("R7 fall flag", v, 8'h40);
    chk("R9 irq after clear", irq, 0);
    rd(5'h05, v); chk("R9 flag cleared", v, 0);
  endtask

  task automatic t_rise;
    logic [7:0] v;
    wr(5'h07, 0);
    pa_in = 8'h80; cyc(4);
    rd(5'h05, v); chk("R6 rise polarity", v, 8'h40);
    pa_in = 8'h00; cyc(4);
    rd(5'h05, v); chk("R7 fall ignored when rising", v, 0);
  endtask

  task automatic t_write_edge;
    logic [7:0] v;
    wr(5'h00, 8'h80); cyc(2);
    rd(5'h05, v); chk("R8 out write under input dir", v, 0);
    wr(5'h01, 8'h80); cyc(2);
    chk("R8 irq", irq, 1);
    chk("R4 pa_oe", pa_oe, 8'h80);
    rd(5'h05, v); chk("R8 dir write edge", v, 8'h40);
    wr(5'h01, 8'h00); cyc(2);
    rd(5'h05, v); chk("R8 falling write ignored", v, 0);
  endtask

  task automatic t_timer;
    logic [7:0] v;
    @(negedge clk); tmr_set = 1; tmr_clr = 1;
    @(negedge clk); tmr_set = 0; tmr_clr = 0;
    chk("R11 timer masked", irq, 0);
    tmr_irq_en = 1; #1 chk("R11 timer irq", irq, 1);
    rd(5'h05, v); chk("R10 timer flag", v, 8'h80);
    rd(5'h05, v); chk("R9 timer kept", v, 8'h80);
    @(negedge clk); tmr_clr = 1;
    @(negedge clk); tmr_clr = 0;
    chk("R10 timer cleared irq", irq, 0);
    rd(5'h05, v); chk("R10 timer cleared", v, 0);
  endtask

  task automatic t_disabled;
    logic [7:0] v;
    wr(5'h05, 0);
    pa_in = 8'h80; cyc(4);
    chk("R6 edge disabled irq", irq, 0);
    rd(5'h05, v); chk("R6 flag still sets", v, 8'h40);
    wr(5'h1E, 8'hFF);
    chk("R6 A4 write pa_out", pa_out, 8'h80);
    chk("R6 A4 write pb_oe", pb_oe, 8'hF0);
    pa_in = 8'h00; cyc(4); pa_in = 8'h80; cyc(4);
    chk("R6 enable unchanged", irq, 0);
  endtask

  initial begin
    cyc(3); @(negedge clk) rst_n = 1; cyc(1);
    t_reset; t_port_b; t_sync; t_fall; t_rise; t_write_edge; t_timer; t_disabled;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule